// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the clock enable, the command strobes, the bank address and the address bus from reset until the memory is ready for ordinary traffic. After reset it holds clock enable low and keeps the chip deselected. It waits for a supply-stable input, then counts a stable-clock interval, which is 200 µs at the default clock. It then issues a fixed series of commands with counted gaps between them. The DLL is enabled through the extended mode register, reset through the base mode register, and both register writes use parameter values.

After two refreshes, the base mode register is written again with the DLL-reset bit cleared, and the block raises a done flag. A separate lock counter starts at the DLL-reset write. A read-permit output stays low until that count has run out and the sequence is done. Every wait length is a parameter in clock cycles, so a test environment can shorten the long stable-clock interval.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it, cke_o is 0, the command strobes {cs_n_o,ras_n_o,cas_n_o,we_n_o} are 1111 (deselect), ba_o and addr_o are 0, and init_done_o and read_ok_o are 0.
- R2: While pwr_stable_i is low, cke_o stays 0 and cs_n_o stays 1.
- R3: cke_o rises only after pwr_stable_i has been high for at least T_STABLE consecutive cycles. If pwr_stable_i drops before then, the count starts again. cs_n_o is 1 on every cycle that cke_o is 0.
- R4: The cycle on which cke_o rises carries NOP (strobes 0111). The next cycle carries PRECHARGE ALL (strobes 0010, addr_o bit 10 set, all other addr_o bits 0, ba_o 0).
- R5: T_RP cycles after the first PRECHARGE ALL, a LOAD MODE (strobes 0000) is issued with ba_o = 01 and addr_o = EXT_MODE.
- R6: T_MRD cycles after that, a LOAD MODE is issued with ba_o = 00 and addr_o = BASE_MODE with bit DLL_RST_BIT set.
- R7: T_MRD cycles after that comes a PRECHARGE ALL. T_RP cycles after it comes an AUTO REFRESH (strobes 0001, ba_o 0, addr_o 0), and a second AUTO REFRESH follows T_RFC cycles later.
- R8: T_RFC cycles after the second refresh, a LOAD MODE is issued with ba_o = 00 and addr_o = BASE_MODE with bit DLL_RST_BIT cleared. init_done_o rises T_MRD cycles later and then stays high with cke_o high.
- R9: read_ok_o rises on the later of two cycles: T_DLL cycles after the DLL-reset LOAD MODE, or the cycle on which init_done_o rises.
- R10: Every cycle with cke_o high that carries none of the listed commands carries NOP. Exactly seven non-NOP commands are issued per sequence, including none after init_done_o.
- R11: Pulling rst_ni low part-way through the sequence returns the pins to the R1 state. A later run repeats the whole sequence and the lock count from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_stable_i | input | 1 | Supplies and clock are stable |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete |
| read_ok_o | output | 1 | DLL lock interval over, reads permitted |

## Verification
The lock counter's expiry and the sequence's completion are two independent paths, and both control read_ok_o. The bench sets T_DLL equal to the cycle count from the DLL-reset write to init_done_o, so both events fall on the same cycle. It then requires read_ok_o to rise exactly on that cycle, and never earlier than either event. A reset is also applied while the lock count is still running. The rerun must then show the same coincidence again, which shows that the count restarted rather than carrying over.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int PRE_ALL_BIT = 10;

  typedef enum logic [2:0] {CMD_DESEL, CMD_NOP, CMD_PRE, CMD_REF, CMD_LMR} cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_STABLE, ST_CKE, ST_PRE_A, ST_EMR, ST_MR_RST,
    ST_PRE_B, ST_REF_A, ST_REF_B, ST_MR_RUN, ST_WAIT, ST_DONE
  } st_e;

  typedef struct packed {
    cmd_e              cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic              cke;
    logic              done;
  } pin_req_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R7: an expired wait stays expired until reloaded
  a_r7_timer_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/ddr_dll_lock.sv
module ddr_dll_lock #(
  parameter int T_DLL = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int W = $clog2(T_DLL + 1);

  logic [W-1:0] cnt_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= W'(T_DLL);
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign expired_o = armed_q && (cnt_q == '0);

  // R9: the DLL reset is issued once per sequence, before any expiry
  a_r9_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !expired_o);
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int                T_STABLE    = 10000,
  parameter int                T_RP        = 3,
  parameter int                T_MRD       = 2,
  parameter int                T_RFC       = 8,
  parameter int                CNT_W       = 16,
  parameter logic [ADDR_W-1:0] EXT_MODE    = '0,
  parameter logic [ADDR_W-1:0] BASE_MODE   = 13'h0032,
  parameter int                DLL_RST_BIT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_stable_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             lock_start_o,
  output pin_req_t         req_o
);
  // command state takes one cycle, wait state holds value+1 cycles
  localparam logic [CNT_W-1:0] L_STABLE = CNT_W'(T_STABLE - 2);
  localparam logic [CNT_W-1:0] L_RP     = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] L_MRD    = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] L_RFC    = CNT_W'(T_RFC - 2);
  localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRE_ALL_BIT;

  st_e st_q, st_d, ret_q, ret_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_PWR;
      ret_q <= ST_PWR;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
    end
  end

  always_comb begin
    st_d         = st_q;
    ret_d        = ret_q;
    tmr_load_o   = 1'b0;
    tmr_val_o    = '0;
    lock_start_o = 1'b0;
    req_o        = '{cmd: CMD_NOP, ba: '0, addr: '0, cke: 1'b1, done: 1'b0};
    case (st_q)
      ST_PWR: begin
        req_o.cmd = CMD_DESEL;
        req_o.cke = 1'b0;
        if (pwr_stable_i) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = L_STABLE;
          st_d       = ST_STABLE;
        end
      end
      ST_STABLE: begin
        req_o.cmd = CMD_DESEL;
        req_o.cke = 1'b0;
        if (!pwr_stable_i)   st_d = ST_PWR;
        else if (tmr_zero_i) st_d = ST_CKE;
      end
      ST_CKE: st_d = ST_PRE_A;
      ST_PRE_A, ST_PRE_B: begin
        req_o.cmd  = CMD_PRE;
        req_o.addr = PRE_ADDR;
        tmr_load_o = 1'b1;
        tmr_val_o  = L_RP;
        ret_d      = (st_q == ST_PRE_A) ? ST_EMR : ST_REF_A;
        st_d       = ST_WAIT;
      end
      ST_EMR: begin
        req_o.cmd  = CMD_LMR;
        req_o.ba   = BA_W'(1);
        req_o.addr = EXT_MODE;
        tmr_load_o = 1'b1;
        tmr_val_o  = L_MRD;
        ret_d      = ST_MR_RST;
        st_d       = ST_WAIT;
      end
      ST_MR_RST: begin
        req_o.cmd    = CMD_LMR;
        req_o.addr   = BASE_MODE | DLL_MASK;
        lock_start_o = 1'b1;
        tmr_load_o   = 1'b1;
        tmr_val_o    = L_MRD;
        ret_d        = ST_PRE_B;
        st_d         = ST_WAIT;
      end
      ST_REF_A, ST_REF_B: begin
        req_o.cmd  = CMD_REF;
        tmr_load_o = 1'b1;
        tmr_val_o  = L_RFC;
        ret_d      = (st_q == ST_REF_A) ? ST_REF_B : ST_MR_RUN;
        st_d       = ST_WAIT;
      end
      ST_MR_RUN: begin
        req_o.cmd  = CMD_LMR;
        req_o.addr = BASE_MODE & ~DLL_MASK;
        tmr_load_o = 1'b1;
        tmr_val_o  = L_MRD;
        ret_d      = ST_DONE;
        st_d       = ST_WAIT;
      end
      ST_WAIT: if (tmr_zero_i) st_d = ret_q;
      ST_DONE: req_o.done = 1'b1;
      default: st_d = ST_PWR;
    endcase
  end

  // R7: no command leaves a wait before its count expires
  a_r7_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !tmr_zero_i) |=> (st_q == ST_WAIT));
endmodule

// File: rtl/ddr_cmd_drv.sv
module ddr_cmd_drv
  import ddr_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pin_req_t          req_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic [3:0] strobe_d;

  always_comb begin
    case (req_i.cmd)
      CMD_NOP: strobe_d = 4'b0111;
      CMD_PRE: strobe_d = 4'b0010;
      CMD_REF: strobe_d = 4'b0001;
      CMD_LMR: strobe_d = 4'b0000;
      default: strobe_d = 4'b1111;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o <= 1'b0;
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b1111;
      ba_o   <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      cke_o <= req_i.cke;
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= strobe_d;
      ba_o   <= req_i.ba;
      addr_o <= req_i.addr;
      done_o <= req_i.done;
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int                T_STABLE    = 10000,
  parameter int                T_RP        = 3,
  parameter int                T_MRD       = 2,
  parameter int                T_RFC       = 8,
  parameter int                T_DLL       = 200,
  parameter logic [ADDR_W-1:0] EXT_MODE    = '0,
  parameter logic [ADDR_W-1:0] BASE_MODE   = 13'h0032,
  parameter int                DLL_RST_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_stable_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o,
  output logic              read_ok_o
);
  localparam int T_MAX = max2(max2(T_STABLE, T_RP), max2(T_MRD, T_RFC));
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic             tmr_load, tmr_zero, lock_start, lock_expired;
  logic [CNT_W-1:0] tmr_val;
  pin_req_t         req;

  ddr_init_fsm #(
    .T_STABLE(T_STABLE), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
    .CNT_W(CNT_W), .EXT_MODE(EXT_MODE), .BASE_MODE(BASE_MODE),
    .DLL_RST_BIT(DLL_RST_BIT)
  ) u_fsm (
    .clk_i, .rst_ni, .pwr_stable_i,
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .lock_start_o(lock_start), .req_o(req)
  );

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  ddr_dll_lock #(.T_DLL(T_DLL)) u_lock (
    .clk_i, .rst_ni, .start_i(lock_start), .expired_o(lock_expired)
  );

  ddr_cmd_drv u_drv (
    .clk_i, .rst_ni, .req_i(req),
    .cke_o, .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .ba_o, .addr_o,
    .done_o(init_done_o)
  );

  assign read_ok_o = lock_expired && init_done_o;

  // R3: chip stays deselected while clock enable is low
  a_r3_quiet_while_cke_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cs_n_o);

  // R8: completion is sticky and keeps clock enable high
  a_r8_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> (init_done_o && cke_o));
endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
  localparam int T_STABLE = 40;
  localparam int T_RP     = 3;
  localparam int T_MRD    = 2;
  localparam int T_RFC    = 8;
  localparam int T_DLL    = 23;  // equals DLL-reset-to-done span
  localparam logic [12:0] EXT_MODE  = 13'h0002;
  localparam logic [12:0] BASE_MODE = 13'h0062;
  localparam int DLL_RST_BIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done, rd_ok;
  logic [1:0]  ba;
  logic [12:0] addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_init_seq #(
    .T_STABLE(T_STABLE), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
    .T_DLL(T_DLL), .EXT_MODE(EXT_MODE), .BASE_MODE(BASE_MODE),
    .DLL_RST_BIT(DLL_RST_BIT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_stable_i(pwr),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .init_done_o(done), .read_ok_o(rd_ok)
  );

  // pin monitor
  int          ev_n = 0;
  int          ev_cyc [16];
  logic [3:0]  ev_cmd [16];
  logic [1:0]  ev_ba  [16];
  logic [12:0] ev_addr[16];
  int cke_rise = -1, done_rise = -1, rd_rise = -1, quiet_viol = 0, nop_viol = 0;
  logic prev_cke = 0, prev_done = 0, prev_rd = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cke = 0; prev_done = 0; prev_rd = 0;
    end else begin
      if (!cke && !cs_n) quiet_viol++;
      if (cke && cs_n) nop_viol++;
      if (cke && !prev_cke) cke_rise = cyc;
      if (done && !prev_done) done_rise = cyc;
      if (rd_ok && !prev_rd) rd_rise = cyc;
      if (!cs_n && {ras_n, cas_n, we_n} != 3'b111 && ev_n < 16) begin
        ev_cyc[ev_n] = cyc; ev_cmd[ev_n] = {cs_n, ras_n, cas_n, we_n};
        ev_ba[ev_n] = ba; ev_addr[ev_n] = addr;
        ev_n++;
      end
      prev_cke = cke; prev_done = done; prev_rd = rd_ok;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clear_log();
    ev_n = 0; cke_rise = -1; done_rise = -1; rd_rise = -1;
    quiet_viol = 0; nop_viol = 0;
  endtask

  task automatic check_idle_pins(input string r);
    chk(cke == 1'b0, r, cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, r, {cs_n, ras_n, cas_n, we_n}, 15);
    chk(ba == 2'b00 && addr == 13'h0, r, addr, 0);
    chk(done == 1'b0, r, done, 0);
    chk(rd_ok == 1'b0, r, rd_ok, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr = 1'b0;
    repeat (3) @(negedge clk);
    check_idle_pins("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_pins("R1");
  endtask

  task automatic t_pwr_low();
    clear_log();
    repeat (30) @(negedge clk);
    chk(cke == 1'b0, "R2", cke, 0);
    chk(cs_n == 1'b1, "R2", cs_n, 1);
    chk(ev_n == 0, "R2", ev_n, 0);
  endtask

  // drop supply-stable mid-wait; returns the cycle of the final rise
  task automatic t_pwr_glitch(output int s);
    pwr = 1'b1;
    repeat (T_STABLE / 2) @(negedge clk);
    pwr = 1'b0;
    repeat (5) @(negedge clk);
    chk(cke == 1'b0, "R3", cke, 0);
    pwr = 1'b1;
    s = cyc;
  endtask

  task automatic t_sequence(input int s);
    logic [3:0]  exp_cmd [7];
    logic [1:0]  exp_ba  [7];
    logic [12:0] exp_addr[7];
    int          exp_gap [6];
    string       tag     [7];
    int          exp_rd;
    exp_cmd = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
    exp_ba  = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
    exp_addr = '{13'h0400, EXT_MODE, BASE_MODE | (13'h1 << DLL_RST_BIT), 13'h0400,
                 13'h0, 13'h0, BASE_MODE & ~(13'h1 << DLL_RST_BIT)};
    exp_gap = '{T_RP, T_MRD, T_MRD, T_RP, T_RFC, T_RFC};
    tag = '{"R4", "R5", "R6", "R7", "R7", "R7", "R8"};
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(cke_rise - s >= T_STABLE && cke_rise - s <= T_STABLE + 2, "R3", cke_rise - s, T_STABLE + 1);
    chk(quiet_viol == 0, "R3", quiet_viol, 0);
    chk(ev_n == 7, "R10", ev_n, 7);
    chk(nop_viol == 0, "R10", nop_viol, 0);
    if (ev_n == 7) begin
      chk(ev_cyc[0] - cke_rise == 1, "R4", ev_cyc[0] - cke_rise, 1);
      for (int i = 0; i < 7; i++) begin
        chk(ev_cmd[i] == exp_cmd[i], tag[i], ev_cmd[i], exp_cmd[i]);
        chk(ev_ba[i] == exp_ba[i], tag[i], ev_ba[i], exp_ba[i]);
        chk(ev_addr[i] == exp_addr[i], tag[i], ev_addr[i], exp_addr[i]);
      end
      for (int i = 0; i < 6; i++)
        chk(ev_cyc[i+1] - ev_cyc[i] == exp_gap[i], tag[i+1], ev_cyc[i+1] - ev_cyc[i], exp_gap[i]);
      chk(done_rise - ev_cyc[6] == T_MRD, "R8", done_rise - ev_cyc[6], T_MRD);
      // R9: both conditions meet on one cycle with these parameters
      exp_rd = (ev_cyc[2] + T_DLL > done_rise) ? ev_cyc[2] + T_DLL : done_rise;
      chk(rd_rise == exp_rd, "R9", rd_rise, exp_rd);
    end
    chk(done && cke, "R8", {done, cke}, 3);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R10", {cs_n, ras_n, cas_n, we_n}, 7);
    chk(rd_ok == 1'b1, "R9", rd_ok, 1);
  endtask

  // reset while the lock count is running, then rerun
  task automatic t_mid_reset(output int s);
    clear_log();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 200 && ev_n < 3; i++) @(negedge clk);
    chk(ev_n == 3, "R11", ev_n, 3);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle_pins("R11");
    clear_log();
    rst_n = 1'b1;
    s = cyc;
  endtask

  bit finished = 0;

  initial begin
    int s;
    t_reset();
    t_pwr_low();
    clear_log();
    t_pwr_glitch(s);
    t_sequence(s);
    t_mid_reset(s);
    t_sequence(s);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule